// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port with Retention Domains

This block is a memory-mapped port of four pins. Software writes a direction register and an output data register over a single-cycle register bus, and reads back a pin view register. Each pin either drives a value or is tri-stated. In general-purpose mode, a driven pin carries its output data bit. In address-output mode, a driven pin carries one line of an externally supplied address. Pins with direction 0 are inputs in both modes.

The pin view register mixes two sources. Bits of pins configured as outputs return the stored output data. Bits of input pins return the pin level after a two-stage synchronizer. Both stored registers are cleared by a power-on reset and by hardware standby. They are kept unchanged while a manual reset or software standby is asserted, and bus writes are ignored during that time.

Top module: `gpio4_port`

## Requirements
- R1: While `por_n` is low, direction and output data are 0. Afterwards `pin_oe` is 0, the data register reads 8'hF0, and the pin view register returns the synchronized pin levels.
- R2: A clock edge with `hw_stby` high clears direction and output data to 0, whatever the bus does in that cycle.
- R3: While `man_rst` or `sw_stby` is high (and `hw_stby` is low), direction and output data keep their values and bus writes have no effect.
- R4: The output data register is at address 1. A write stores `bus_wdata[3:0]`, and bits 7..4 of the write are ignored. A read returns the stored bits in [3:0], with 4'hF in bits [7:4], in the same cycle as the address.
- R5: The direction register is at address 0 and is write-only. A write stores `bus_wdata[3:0]`, and a read of address 0 returns 8'hFF. Bit i set to 1 makes pin i an output.
- R6: The pin view register is at address 2. Read bit i is the output data bit when direction bit i is 1, and otherwise the pin level sampled two clock edges earlier. Bits [7:4] read 4'hF.
- R7: Writes to address 2 (pin view) and address 3 (unused) change no state. Address 3 reads 8'hFF.
- R8: With `addr_mode` low, `pin_oe` equals the direction bits and a driven pin outputs its data bit. `pin_out` is 0 on every undriven pin.
- R9: With `addr_mode` high, `pin_oe` still equals the direction bits, but a driven pin outputs the matching `addr_in` bit instead of its data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| man_rst | input | 1 | Manual reset: holds state, blocks writes |
| hw_stby | input | 1 | Hardware standby: clears state on the edge |
| sw_stby | input | 1 | Software standby: holds state, blocks writes |
| addr_mode | input | 1 | 1 = driven pins carry address lines |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| addr_in | input | 4 | Address lines used in address-output mode |
| pin_in | input | 4 | Pin levels, asynchronous |
| pin_oe | output | 4 | Per-pin output enable |
| pin_out | output | 4 | Per-pin output value |

## Verification
On every cycle, the assertions check four things: writes that land in the registers, retention while manual reset or software standby is high, the clear by hardware standby, and the pin multiplexer in both modes. Other behaviour can only be shown by the bench's scenarios. This covers the mixed readback of the pin view register across many direction and pin patterns, and the two-edge latency of the synchronizer. It also covers the constant filler bits, the write-only direction readback, and the fact that the register state survives a long hold and can afterwards still be read and written.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
  localparam int NPINS = 4;
  localparam int DW    = 8;
  localparam int AW    = 2;

  typedef enum logic [AW-1:0] {
    SEL_DIR  = 2'd0,
    SEL_DAT  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Per-bit choice between stored data and sampled pin level
  function automatic logic [NPINS-1:0] pin_view(input logic [NPINS-1:0] dir,
                                                input logic [NPINS-1:0] dat,
                                                input logic [NPINS-1:0] smp);
    return (dir & dat) | (~dir & smp);
  endfunction

  // Value placed on a pin given mode, enable, data and address line
  function automatic logic drive_bit(input logic amode, input logic en,
                                     input logic d, input logic a);
    return en & (amode ? a : d);
  endfunction

  // Widen a nibble to a bus byte, padding unused bits with ones
  function automatic logic [DW-1:0] pad_ones(input logic [NPINS-1:0] v);
    return {{(DW-NPINS){1'b1}}, v};
  endfunction
endpackage

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[LAST];
  end
endmodule

// File: rtl/gpio4_regs.sv
module gpio4_regs
  import gpio4_pkg::*;
#(
  parameter int W = NPINS
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         hw_stby,
  input  logic         hold_req,
  input  logic         wr_dir,
  input  logic         wr_dat,
  input  logic [DW-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] dat_q
);
  logic dir_load, dat_load, clr_ev, hold_ev;

  assign clr_ev   = hw_stby;
  assign hold_ev  = hold_req & ~hw_stby;
  assign dir_load = wr_dir & ~hold_req & ~hw_stby;
  assign dat_load = wr_dat & ~hold_req & ~hw_stby;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (clr_ev) begin
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      if (dir_load) dir_q <= wdata[W-1:0];
      if (dat_load) dat_q <= wdata[W-1:0];
    end
  end

  assert_stby_clear_R2: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |=> (dir_q == '0 && dat_q == '0));

  assert_hold_keeps_R3: assert property (@(posedge clk) disable iff (!por_n)
    hold_ev |=> ($stable(dir_q) && $stable(dat_q)));

  assert_dat_write_R4: assert property (@(posedge clk) disable iff (!por_n)
    dat_load |=> (($past(wdata) & {{(DW-W){1'b0}}, {W{1'b1}}}) == {{(DW-W){1'b0}}, dat_q}));

  assert_dir_write_R5: assert property (@(posedge clk) disable iff (!por_n)
    dir_load |=> (($past(wdata) & {{(DW-W){1'b0}}, {W{1'b1}}}) == {{(DW-W){1'b0}}, dir_q}));
endmodule

// File: rtl/gpio4_pinmux.sv
module gpio4_pinmux
  import gpio4_pkg::*;
#(
  parameter int W = NPINS
) (
  input  logic         amode,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] dat,
  input  logic [W-1:0] addr,
  output logic [W-1:0] oe,
  output logic [W-1:0] out
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign oe[i]  = dir[i];
    assign out[i] = drive_bit(amode, dir[i], dat[i], addr[i]);
  end
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
  import gpio4_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              man_rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              addr_mode,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  addr_in,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_out
);
  localparam int SYNC_STAGES = 2;

  reg_sel_e         sel;
  logic             wr_dir_ev, wr_dat_ev, wr_ro_ev, hold_req;
  logic [NPINS-1:0] dir_q, dat_q, smp;

  assign sel       = reg_sel_e'(bus_addr);
  assign hold_req  = man_rst | sw_stby;
  assign wr_dir_ev = bus_wr & (sel == SEL_DIR);
  assign wr_dat_ev = bus_wr & (sel == SEL_DAT);
  assign wr_ro_ev  = bus_wr & ((sel == SEL_PIN) | (sel == SEL_NONE));

  gpio4_regs #(.W(NPINS)) u_regs (
    .clk      (clk),
    .por_n    (por_n),
    .hw_stby  (hw_stby),
    .hold_req (hold_req),
    .wr_dir   (wr_dir_ev),
    .wr_dat   (wr_dat_ev),
    .wdata    (bus_wdata),
    .dir_q    (dir_q),
    .dat_q    (dat_q)
  );

  gpio4_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .por_n (por_n),
    .din   (pin_in),
    .dout  (smp)
  );

  gpio4_pinmux #(.W(NPINS)) u_mux (
    .amode (addr_mode),
    .dir   (dir_q),
    .dat   (dat_q),
    .addr  (addr_in),
    .oe    (pin_oe),
    .out   (pin_out)
  );

  always_comb begin
    unique case (sel)
      SEL_DAT: bus_rdata = pad_ones(dat_q);
      SEL_PIN: bus_rdata = pad_ones(pin_view(dir_q, dat_q, smp));
      default: bus_rdata = '1;
    endcase
  end

  assert_ro_write_R7: assert property (@(posedge clk) disable iff (!por_n)
    (wr_ro_ev && !hw_stby) |=> ($stable(dir_q) && $stable(dat_q)));

  assert_gp_drive_R8: assert property (@(posedge clk) disable iff (!por_n)
    !addr_mode |-> ((pin_out == (dat_q & pin_oe)) && (pin_oe == dir_q)));

  assert_addr_drive_R9: assert property (@(posedge clk) disable iff (!por_n)
    addr_mode |-> ((pin_out == (addr_in & pin_oe)) && (pin_oe == dir_q)));

  assert_por_clear_R1: assert property (@(posedge clk)
    !por_n |-> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/tb_gpio4_port.sv
module tb_gpio4_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n, man_rst, hw_stby, sw_stby, addr_mode, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [3:0] addr_in, pin_in, pin_oe, pin_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] m_dir, m_dat;

  gpio4_port dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] exp_view(logic [3:0] d, logic [3:0] q, logic [3:0] p);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = d[i] ? q[i] : p[i];
    return r;
  endfunction

  function automatic logic [3:0] exp_out(logic am, logic [3:0] d, logic [3:0] q, logic [3:0] a);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = !d[i] ? 1'b0 : (am ? a[i] : q[i]);
    return r;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic check_all(string tag);
    logic [7:0] v;
    rd(2'd1, v); chk({tag, " R4 data"}, v, {4'hF, m_dat});
    rd(2'd2, v); chk({tag, " R6 view"}, v, {4'hF, exp_view(m_dir, m_dat, pin_in)});
    rd(2'd0, v); chk({tag, " R5 dir readback"}, v, 8'hFF);
    chk({tag, " R8/R9 oe"}, {4'h0, pin_oe}, {4'h0, m_dir});
    chk({tag, addr_mode ? " R9 out" : " R8 out"}, {4'h0, pin_out},
        {4'h0, exp_out(addr_mode, m_dir, m_dat, addr_in)});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);
    por_n = 0; man_rst = 0; hw_stby = 0; sw_stby = 0; addr_mode = 0;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0; addr_in = 4'h9; pin_in = 4'hA;
    m_dir = 0; m_dat = 0;
    tick(3);
    chk("R1 oe in reset", {4'h0, pin_oe}, 8'h00);
    por_n = 1;
    tick(3);
    check_all("R1 after por");

    // R4: upper write bits ignored
    bus_write(2'd1, 8'hA5); m_dat = 4'h5;
    rd(2'd1, v); chk("R4 upper ignored", v, 8'hF5);
    // R5 direction write
    bus_write(2'd0, 8'h3C); m_dir = 4'hC;
    check_all("R5 dir set");
    // R7 writes to read-only and unused addresses
    bus_write(2'd2, 8'h0F);
    check_all("R7 pin addr write");
    bus_write(2'd3, 8'h00);
    rd(2'd3, v); chk("R7 unused read", v, 8'hFF);
    check_all("R7 unused write");
    // R6 synchronizer latency: new level visible after two edges, not one
    bus_write(2'd0, 8'h00); m_dir = 4'h0;
    pin_in = 4'h3; tick(1);
    rd(2'd2, v); chk("R6 one edge old", v, 8'hFA);
    tick(1);
    rd(2'd2, v); chk("R6 two edges new", v, 8'hF3);
    // R9 address mode
    bus_write(2'd0, 8'h0F); m_dir = 4'hF;
    addr_mode = 1; addr_in = 4'h6; #1;
    check_all("R9 addr mode");
    addr_mode = 0;
    // R3 manual reset and software standby retention
    man_rst = 1;
    bus_write(2'd1, 8'h0A); bus_write(2'd0, 8'h01);
    tick(5);
    check_all("R3 man_rst hold");
    man_rst = 0; sw_stby = 1;
    bus_write(2'd1, 8'h00);
    check_all("R3 sw_stby hold");
    sw_stby = 0;
    // R2 hardware standby clears, even with a concurrent write
    hw_stby = 1;
    bus_write(2'd1, 8'h0F);
    hw_stby = 0; m_dir = 0; m_dat = 0;
    tick(3);
    check_all("R2 hw_stby clear");

    // Random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [7:0] d;
      op = $urandom_range(0, 9);
      d  = 8'($urandom);
      case (op)
        0, 1: begin bus_write(2'd1, d); m_dat = d[3:0]; end
        2, 3: begin bus_write(2'd0, d); m_dir = d[3:0]; end
        4: bus_write(2'($urandom_range(2, 3)), d);
        5: begin pin_in = d[3:0]; tick(2); end
        6: begin addr_mode = ~addr_mode; addr_in = d[7:4]; #1; end
        7: begin
          man_rst = d[0]; sw_stby = ~d[0];
          bus_write(2'(d[1]), d);
          man_rst = 0; sw_stby = 0;
        end
        8: if (d[7:5] == 3'b000) begin
          hw_stby = 1; tick(); hw_stby = 0; m_dir = 0; m_dat = 0;
        end
        default: begin addr_in = d[3:0]; #1; end
      endcase
      check_all("rand");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule